// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block performs one-bit logic with the carry flag acting as a one-bit accumulator. Each operation names a bit through an 8-bit bit address. The block turns that address into a byte address and a bit index. It reads the byte over an asynchronous read port, then acts on either the carry or the addressed bit.

The block can clear, set or complement the carry or the bit. It can AND or OR the bit into carry, in true or inverted form. It can copy the bit into carry, or carry into the bit. It also evaluates the three bit-test branch conditions: branch on set, branch on clear, and branch on set with clear.

When an operation changes a bit, the block writes the whole byte back one cycle later with only the selected bit changed. All results are registered and appear on the cycle after the operation is presented. Updating the program counter is left to the surrounding core.

Top module: `bool_proc`

## Requirements
- R1: While `rstN` is low, and after it, `resValid`, `memWe`, `branchTaken` and `cyOut` are 0 until an operation is accepted.
- R2: An operation presented with `opValid` high is reflected on `resValid`, `cyOut`, `memWe`, `memWrAddr`, `memWrData` and `branchTaken` after the next rising clock edge. A cycle with `opValid` low produces `resValid`=0, `memWe`=0 and `branchTaken`=0, and leaves `cyOut` unchanged.
- R3: Bit address mapping for `memRdAddr`/`memWrAddr`. A bit address below 0x80 selects byte 0x20 + addr[6:3]. A bit address of 0x80 or above selects byte {addr[7:3],000}. In both cases the bit index is addr[2:0].
- R4: Codes 0, 1 and 2 clear, set and complement the carry. None of them writes memory.
- R5: Codes 3, 4 and 5 clear, set and complement the addressed bit through a byte write. The carry is left unchanged.
- R6: Code 6 gives CY AND bit, code 7 gives CY AND NOT bit, code 8 gives CY OR bit and code 9 gives CY OR NOT bit. None of them writes memory.
- R7: Code 10 copies the addressed bit into the carry without a write. Code 11 writes the carry into the addressed bit and leaves the carry unchanged.
- R8: Code 12 is taken when the bit is 1 and code 13 is taken when the bit is 0. Neither writes memory nor changes the carry.
- R9: Code 14 is taken when the bit is 1, and then writes the byte back with that bit cleared. When the bit is 0 it is not taken and issues no write. The carry is unchanged.
- R10: Code 15 does nothing. No code other than 12 to 14 ever raises `branchTaken`.
- R11: Every byte write equals the byte that was read, except at the selected bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| bitAddr | input | 8 | Bit address |
| memRdAddr | output | 8 | Byte address to read, combinational from `bitAddr` |
| memRdData | input | 8 | Byte read at `memRdAddr`, same cycle |
| cyIn | input | 1 | Current carry flag |
| resValid | output | 1 | Result of an operation is on the outputs |
| cyOut | output | 1 | New carry flag |
| memWe | output | 1 | Byte write strobe |
| memWrAddr | output | 8 | Byte write address |
| memWrData | output | 8 | Updated byte |
| branchTaken | output | 1 | Branch condition met |

## Verification
The bench targets the four ends of the address map: 0x00, 0x7F, 0x80 and 0xFF. A design with a wrong map would write into the wrong byte, for example byte 0x00 instead of 0x20, or byte 0xFF instead of 0xF8.

It drives the inverted AND/OR forms with both carry values. A design that drops the inversion gives the wrong carry in half of those cases.

It runs the test-and-clear operation on both a set bit and a clear bit. A design that skips the write would leave the flag set. A design that writes on every call would issue needless writes.

Random bytes check that a bit write never disturbs the other seven bits. Idle cycles check that no stale write or branch is left behind.

// File: rtl/bool_proc_pkg.sv
package bool_proc_pkg;
  typedef enum logic [3:0] {
    OP_CLR_C = 4'd0, OP_SET_C = 4'd1, OP_CPL_C = 4'd2,
    OP_CLR_B = 4'd3, OP_SET_B = 4'd4, OP_CPL_B = 4'd5,
    OP_AND_B = 4'd6, OP_AND_NB = 4'd7, OP_OR_B = 4'd8, OP_OR_NB = 4'd9,
    OP_LD_C = 4'd10, OP_ST_C = 4'd11,
    OP_BR_SET = 4'd12, OP_BR_CLR = 4'd13, OP_BR_TCLR = 4'd14, OP_NOP = 4'd15
  } bpOp_e;

  typedef enum logic [2:0] {
    CY_KEEP, CY_ZERO, CY_ONE, CY_INV, CY_AND, CY_OR, CY_BIT
  } cySel_e;

  typedef enum logic [2:0] {
    BIT_KEEP, BIT_ZERO, BIT_ONE, BIT_INV, BIT_FROM_CY, BIT_CLR_IF_SET
  } bitSel_e;

  typedef enum logic [1:0] {BR_NONE, BR_IF_SET, BR_IF_CLR} brSel_e;

  typedef struct packed {
    cySel_e  cySel;
    bitSel_e bitSel;
    brSel_e  brSel;
    logic    invOpnd;
  } bpStrobe_t;
endpackage

// File: rtl/bool_proc_ctrl.sv
module bool_proc_ctrl
  import bool_proc_pkg::*;
(
  input  logic [3:0] opCode,
  output bpStrobe_t  strobe
);
  always_comb begin
    strobe = '{cySel: CY_KEEP, bitSel: BIT_KEEP, brSel: BR_NONE, invOpnd: 1'b0};
    case (bpOp_e'(opCode))
      OP_CLR_C:   strobe.cySel = CY_ZERO;
      OP_SET_C:   strobe.cySel = CY_ONE;
      OP_CPL_C:   strobe.cySel = CY_INV;
      OP_CLR_B:   strobe.bitSel = BIT_ZERO;
      OP_SET_B:   strobe.bitSel = BIT_ONE;
      OP_CPL_B:   strobe.bitSel = BIT_INV;
      OP_AND_B:   strobe.cySel = CY_AND;
      OP_AND_NB: begin
        strobe.cySel   = CY_AND;
        strobe.invOpnd = 1'b1;
      end
      OP_OR_B:    strobe.cySel = CY_OR;
      OP_OR_NB: begin
        strobe.cySel   = CY_OR;
        strobe.invOpnd = 1'b1;
      end
      OP_LD_C:    strobe.cySel = CY_BIT;
      OP_ST_C:    strobe.bitSel = BIT_FROM_CY;
      OP_BR_SET:  strobe.brSel = BR_IF_SET;
      OP_BR_CLR:  strobe.brSel = BR_IF_CLR;
      OP_BR_TCLR: begin
        strobe.brSel  = BR_IF_SET;
        strobe.bitSel = BIT_CLR_IF_SET;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bool_proc_dp.sv
module bool_proc_dp
  import bool_proc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  bpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] bitAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              cyIn,
  output logic              resValid,
  output logic              cyOut,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              branchTaken
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] byteAddr;
  logic [IDX_W-1:0]  bitIdx;
  logic              curBit, opnd, newCy, newBit, doWrite, taken;
  logic [DATA_W-1:0] newByte;

  always_comb begin
    if (!bitAddr[ADDR_W-1])
      byteAddr = BIT_BASE + ADDR_W'(bitAddr[ADDR_W-2:IDX_W]);
    else
      byteAddr = {bitAddr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  end

  assign memRdAddr = byteAddr;
  assign bitIdx    = bitAddr[IDX_W-1:0];
  assign curBit    = memRdData[bitIdx];
  assign opnd      = curBit ^ strobe.invOpnd;

  always_comb begin
    case (strobe.cySel)
      CY_ZERO: newCy = 1'b0;
      CY_ONE:  newCy = 1'b1;
      CY_INV:  newCy = ~cyIn;
      CY_AND:  newCy = cyIn & opnd;
      CY_OR:   newCy = cyIn | opnd;
      CY_BIT:  newCy = curBit;
      default: newCy = cyIn;
    endcase
  end

  always_comb begin
    newBit  = curBit;
    doWrite = 1'b1;
    case (strobe.bitSel)
      BIT_ZERO:       newBit = 1'b0;
      BIT_ONE:        newBit = 1'b1;
      BIT_INV:        newBit = ~curBit;
      BIT_FROM_CY:    newBit = cyIn;
      BIT_CLR_IF_SET: begin
        newBit  = 1'b0;
        doWrite = curBit;
      end
      default:        doWrite = 1'b0;
    endcase
    newByte         = memRdData;
    newByte[bitIdx] = newBit;
  end

  always_comb begin
    case (strobe.brSel)
      BR_IF_SET: taken = curBit;
      BR_IF_CLR: taken = ~curBit;
      default:   taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      cyOut       <= 1'b0;
      memWe       <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
      branchTaken <= 1'b0;
    end else begin
      resValid    <= opValid;
      memWe       <= opValid & doWrite;
      branchTaken <= opValid & taken;
      if (opValid) begin
        cyOut     <= newCy;
        memWrAddr <= byteAddr;
        memWrData <= newByte;
      end
    end
  end
endmodule

// File: rtl/bool_proc.sv
module bool_proc
  import bool_proc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [ADDR_W-1:0] bitAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              cyIn,
  output logic              resValid,
  output logic              cyOut,
  output logic              memWe,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              branchTaken
);
  bpStrobe_t strobe;

  bool_proc_ctrl u_ctrl (.opCode(opCode), .strobe(strobe));

  bool_proc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIT_BASE(BIT_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .opValid(opValid), .strobe(strobe),
    .bitAddr(bitAddr), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .cyIn(cyIn), .resValid(resValid), .cyOut(cyOut), .memWe(memWe),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .branchTaken(branchTaken)
  );
endmodule

// File: rtl/bool_proc_chk.sv
module bool_proc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [7:0] bitAddr,
  input logic [7:0] memRdData,
  input logic       cyIn,
  input logic       cyOut,
  input logic       memWe,
  input logic [7:0] memWrAddr,
  input logic [7:0] memWrData,
  input logic       branchTaken
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(opValid) |-> (!memWe && !branchTaken && cyOut == $past(cyOut)));

  assert_map_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWrAddr == ($past(bitAddr[7]) ? {$past(bitAddr[7:3]), 3'b000}
                                               : (8'h20 + {4'b0, $past(bitAddr[6:3])}))));

  assert_cy_ops_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode <= 4'd2) |-> !memWe);

  assert_test_only_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && (opCode == 4'd12 || opCode == 4'd13)) |-> (!memWe && cyOut == $past(cyIn)));

  assert_tclr_write_iff_taken_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode == 4'd14) |-> (memWe == branchTaken));

  assert_branch_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> $past(opValid && opCode >= 4'd12 && opCode <= 4'd14));

  assert_single_bit_R11: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (((memWrData ^ $past(memRdData)) & ~(8'd1 << $past(bitAddr[2:0]))) == 8'd0));
endmodule

bind bool_proc bool_proc_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .bitAddr(bitAddr),
  .memRdData(memRdData), .cyIn(cyIn), .cyOut(cyOut), .memWe(memWe),
  .memWrAddr(memWrAddr), .memWrData(memWrData), .branchTaken(branchTaken)
);

// File: tb/bool_proc_test.sv
`timescale 1ns/1ps
module bool_proc_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] bitAddr = 8'd0;
  logic [7:0] memRdAddr;
  logic [7:0] memRdData = 8'd0;
  logic       cyIn = 1'b0;
  logic       resValid, cyOut, memWe, branchTaken;
  logic [7:0] memWrAddr, memWrData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bool_proc uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .bitAddr(bitAddr),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .cyIn(cyIn), .resValid(resValid),
    .cyOut(cyOut), .memWe(memWe), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .branchTaken(branchTaken)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mapAddr(input logic [7:0] a);
    return a[7] ? {a[7:3], 3'b000} : (8'h20 + {4'b0, a[6:3]});
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    if (op <= 2) return "R4";
    if (op <= 5) return "R5";
    if (op <= 9) return "R6";
    if (op <= 11) return "R7";
    if (op <= 13) return "R8";
    if (op == 14) return "R9";
    return "R10";
  endfunction

  function automatic void model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] rd,
                                input logic cy, output logic eCy, output logic eWe,
                                output logic [7:0] eData, output logic eBr);
    logic b;
    b = rd[a[2:0]];
    eCy = cy; eWe = 1'b0; eData = rd; eBr = 1'b0;
    case (op)
      4'd0: eCy = 1'b0;
      4'd1: eCy = 1'b1;
      4'd2: eCy = ~cy;
      4'd3: begin eWe = 1'b1; eData[a[2:0]] = 1'b0; end
      4'd4: begin eWe = 1'b1; eData[a[2:0]] = 1'b1; end
      4'd5: begin eWe = 1'b1; eData[a[2:0]] = ~b; end
      4'd6: eCy = cy & b;
      4'd7: eCy = cy & ~b;
      4'd8: eCy = cy | b;
      4'd9: eCy = cy | ~b;
      4'd10: eCy = b;
      4'd11: begin eWe = 1'b1; eData[a[2:0]] = cy; end
      4'd12: eBr = b;
      4'd13: eBr = ~b;
      4'd14: begin eBr = b; eWe = b; eData[a[2:0]] = 1'b0; end
      default: ;
    endcase
  endfunction

  task automatic runOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] rd,
                       input logic cy);
    logic eCy, eWe, eBr;
    logic [7:0] eData;
    string r;
    r = reqOf(op);
    model(op, a, rd, cy, eCy, eWe, eData, eBr);
    @(negedge clk);
    opValid = 1'b1; opCode = op; bitAddr = a; memRdData = rd; cyIn = cy;
    #1;
    chk(memRdAddr == mapAddr(a), "R3 read address", memRdAddr, mapAddr(a));
    @(posedge clk);
    #1;
    chk(resValid == 1'b1, "R2 valid", resValid, 1);
    chk(cyOut == eCy, {r, " carry"}, cyOut, eCy);
    chk(memWe == eWe, {r, " write strobe"}, memWe, eWe);
    chk(branchTaken == eBr, {r, " branch"}, branchTaken, eBr);
    if (eWe && memWe) begin
      chk(memWrAddr == mapAddr(a), "R3 write address", memWrAddr, mapAddr(a));
      chk(memWrData == eData, {r, " R11 write data"}, memWrData, eData);
    end
  endtask

  task automatic idleCycle();
    logic prevCy;
    @(negedge clk);
    prevCy = cyOut;
    opValid = 1'b0;
    opCode = 4'($urandom);
    bitAddr = 8'($urandom);
    memRdData = 8'($urandom);
    cyIn = 1'($urandom);
    @(posedge clk);
    #1;
    chk(!resValid && !memWe && !branchTaken, "R2 idle quiet",
        {resValid, memWe, branchTaken}, 0);
    chk(cyOut == prevCy, "R2 idle carry hold", cyOut, prevCy);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk(!resValid && !memWe && !branchTaken && !cyOut, "R1 reset state",
        {resValid, memWe, branchTaken, cyOut}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(!resValid && !memWe && !branchTaken && !cyOut, "R1 after reset",
        {resValid, memWe, branchTaken, cyOut}, 0);

    // R3 map corners
    runOp(4'd4, 8'h00, 8'h00, 1'b0);
    runOp(4'd4, 8'h7F, 8'h00, 1'b0);
    runOp(4'd3, 8'h80, 8'hFF, 1'b1);
    runOp(4'd3, 8'hFF, 8'hFF, 1'b1);
    // R6 inverted forms, both carries
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 2; v++) begin
        runOp(4'd7, 8'h13, v ? 8'h08 : 8'h00, 1'(c));
        runOp(4'd9, 8'h13, v ? 8'h08 : 8'h00, 1'(c));
      end
    // R9 test-and-clear on set and clear bit
    runOp(4'd14, 8'h85, 8'hFF, 1'b0);
    runOp(4'd14, 8'h85, 8'hDF, 1'b1);
    // R10 no-op
    runOp(4'd15, 8'h22, 8'h5A, 1'b1);
    idleCycle();

    for (int i = 0; i < 600; i++) begin
      runOp(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
      if (($urandom % 8) == 0) idleCycle();
    end

    @(negedge clk);
    opValid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule